// File: doc/BRIEF.md
# Cascaded Modulator Noise-Cancellation Filter

This block recombines the three tri-level output streams of a three-stage cascaded sigma-delta modulator into a single signed word, so that the quantization error of the first two stages cancels. Each modulator clock supplies one two-bit code per stage, qualified by a valid strobe. The second-stage stream passes through the second-order difference filter H1(z) = 1 − 2z⁻¹ + 1.03125z⁻². The third-stage stream passes through the third-order filter H2(z) = 1 − 3z⁻¹ + 3.03125z⁻² − 1.03125z⁻³. The first-stage stream is delayed to line up with them, and the three paths are summed.

All tap weights are built from shifts and adds: 1.03125 is x + x/32. Internally every term is kept in units of 1/32, so that no product loses a bit. The sum is then rescaled to the output format and clamped to the 11-bit signed range. The block has a two-stage pipeline. The first stage registers the three path sums and the second registers the saturated total, so a result leaves exactly two clocks after its sample was accepted.

Top module: `mash_noise_cancel`

## Requirements
- R1: A synchronous active-high reset clears all delay lines and pipeline registers. In the cycle after reset, out_valid is 0 and out_word is 0. Samples that arrive after reset see zero history.
- R2: Each two-bit code maps 2'b01 to +1, 2'b00 to 0 and 2'b11 to −1.
- R3: The code 2'b10 is illegal and is treated as 0 on every stage.
- R4: The first-stage stream reaches the sum with unit weight, delayed by exactly 3 accepted samples: its term is x1[n−3].
- R5: The second-stage stream is filtered by H1 and delayed by one extra sample so that its delay matches H2. Its term is x2[n−1] − 2·x2[n−2] + 1.03125·x2[n−3].
- R6: The third-stage stream contributes x3[n] − 3·x3[n−1] + 3.03125·x3[n−2] − 1.03125·x3[n−3].
- R7: out_word is an 11-bit two's-complement value with 7 fractional bits, so the output integer is the real sum times 128. It is 0 in every cycle in which out_valid is 0.
- R8: A sum above 1023/128 gives out_word = 1023 and a sum below −1024/128 gives −1024. The output saturates and never wraps.
- R9: Each cycle with in_valid high produces exactly one cycle with out_valid high, two clocks later. A cycle with in_valid low produces none.
- R10: The delay lines advance only on cycles with in_valid high. Idle cycles leave the filter history unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The three codes form one accepted sample |
| code_s1 | input | 2 | Tri-level code from the first modulator stage |
| code_s2 | input | 2 | Tri-level code from the second modulator stage |
| code_s3 | input | 2 | Tri-level code from the third modulator stage |
| out_valid | output | 1 | out_word carries a result this cycle |
| out_word | output | 11 | Saturated signed sum, 7 fractional bits |

## Verification
Saturation and illegal-code substitution can act on the same sample. The bench forces this by driving alternating-sign codes into the second and third stages, which pushes the sum past either rail, while 2'b10 is injected on one or more stages within that same burst. A behavioural model decodes the codes, keeps its own per-stage history and clamps its arithmetic sum, and it is compared with the ports on every clock. Accepted samples are also interleaved with idle cycles. This shows that an output emerging from the pipeline never coincides with a history shift caused by an idle cycle.

// File: rtl/mash_nc_pkg.sv
package mash_nc_pkg;

    // tri-level sample value: -1, 0, +1
    typedef logic signed [1:0] tri_t;

    // history taps held per stage (delay of the longest filter)
    localparam int TAPS     = 3;
    // internal scale: every term is kept in units of 2^-INT_FRAC
    localparam int INT_FRAC = 5;
    // width of one path sum in internal units (|H2| max 258)
    localparam int PATH_W   = 12;
    localparam int NSTAGE   = 3;

    typedef logic signed [PATH_W-1:0] path_t;

    typedef enum logic [1:0] {
        PATH_DIRECT = 2'd0,
        PATH_H1     = 2'd1,
        PATH_H2     = 2'd2
    } path_kind_e;

    function automatic tri_t decode_code(input logic [1:0] c);
        tri_t v;
        case (c)
            2'b01:   v = 2'sd1;
            2'b11:   v = -2'sd1;
            default: v = 2'sd0;   // 2'b00 and the illegal 2'b10
        endcase
        return v;
    endfunction

    function automatic path_t widen(input tri_t v);
        return path_t'(v);
    endfunction

    // multiples of a tri value built from shifts and adds only
    function automatic path_t mul32(input tri_t v);
        return widen(v) <<< 5;
    endfunction

    function automatic path_t mul33(input tri_t v);
        return (widen(v) <<< 5) + widen(v);
    endfunction

    function automatic path_t mul64(input tri_t v);
        return widen(v) <<< 6;
    endfunction

    function automatic path_t mul96(input tri_t v);
        return (widen(v) <<< 6) + (widen(v) <<< 5);
    endfunction

    function automatic path_t mul97(input tri_t v);
        return (widen(v) <<< 6) + (widen(v) <<< 5) + widen(v);
    endfunction

    // weight of tap idx (0 = current sample, k = k samples back),
    // scaled by 2^INT_FRAC, for the given path variant
    function automatic path_t tap_term(input path_kind_e kind, input int idx,
                                       input tri_t v);
        path_t t;
        t = '0;
        case (kind)
            PATH_DIRECT: begin
                if (idx == 3) t = mul32(v);
            end
            PATH_H1: begin
                case (idx)
                    1:       t = mul32(v);
                    2:       t = -mul64(v);
                    3:       t = mul33(v);
                    default: t = '0;
                endcase
            end
            default: begin
                case (idx)
                    0:       t = mul32(v);
                    1:       t = -mul96(v);
                    2:       t = mul97(v);
                    3:       t = -mul33(v);
                    default: t = '0;
                endcase
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/mash_tap_line.sv
module mash_tap_line
    import mash_nc_pkg::*;
#(
    parameter int DEPTH = TAPS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_en,
    input  tri_t                   din,
    output tri_t [DEPTH-1:0]       taps
);

    // taps[0] is one accepted sample back, taps[DEPTH-1] is DEPTH back
    tri_t [DEPTH-1:0] line_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            tri_t cell_d;
            if (i == 0) begin : g_head
                assign cell_d = din;
            end else begin : g_body
                assign cell_d = line_q[i-1];
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    line_q[i] <= '0;
                end else if (shift_en) begin
                    line_q[i] <= cell_d;
                end
            end
        end
    endgenerate

    assign taps = line_q;

endmodule

// File: rtl/mash_cancel_path.sv
module mash_cancel_path
    import mash_nc_pkg::*;
#(
    parameter path_kind_e KIND = PATH_DIRECT
) (
    input  logic             clk,
    input  logic             rst,
    input  tri_t             cur,
    input  tri_t [TAPS-1:0]  taps,
    output path_t            psum
);

    path_t sum_d;
    path_t sum_q;

    always_comb begin
        sum_d = tap_term(KIND, 0, cur);
        for (int k = 0; k < TAPS; k++) begin
            sum_d = sum_d + tap_term(KIND, k + 1, taps[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign psum = sum_q;

endmodule

// File: rtl/mash_combiner.sv
module mash_combiner
    import mash_nc_pkg::*;
#(
    parameter int OUT_W    = 11,
    parameter int OUT_FRAC = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vin,
    input  path_t                    p_a,
    input  path_t                    p_b,
    input  path_t                    p_c,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_word
);

    localparam int SHIFT = OUT_FRAC - INT_FRAC;
    localparam int SUM_W = PATH_W + 2 + SHIFT;
    localparam int MAXV  = (1 <<< (OUT_W - 1)) - 1;
    localparam int MINV  = -(1 <<< (OUT_W - 1));

    typedef logic signed [SUM_W-1:0] sum_t;
    typedef logic signed [OUT_W-1:0] word_t;

    sum_t  total;
    sum_t  scaled;
    word_t clamped;

    always_comb begin
        total  = sum_t'(p_a) + sum_t'(p_b) + sum_t'(p_c);
        scaled = total <<< SHIFT;
        if (scaled > sum_t'(MAXV)) begin
            clamped = word_t'(MAXV);
        end else if (scaled < sum_t'(MINV)) begin
            clamped = word_t'(MINV);
        end else begin
            clamped = word_t'(scaled);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= vin;
            out_word  <= vin ? clamped : '0;
        end
    end

endmodule

// File: rtl/mash_noise_cancel.sv
module mash_noise_cancel
    import mash_nc_pkg::*;
#(
    parameter int OUT_W    = 11,
    parameter int OUT_FRAC = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [1:0]               code_s1,
    input  logic [1:0]               code_s2,
    input  logic [1:0]               code_s3,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_word
);

    localparam int HIST_W = NSTAGE * TAPS * 2;

    tri_t              dec   [NSTAGE];
    tri_t [TAPS-1:0]   taps  [NSTAGE];
    path_t             psum  [NSTAGE];
    logic              valid_s1;

    // flattened views for the bound checker
    logic [HIST_W-1:0] hist_flat;
    tri_t              dec_s1;
    tri_t [TAPS-1:0]   taps_s1;

    assign dec[0] = decode_code(code_s1);
    assign dec[1] = decode_code(code_s2);
    assign dec[2] = decode_code(code_s3);

    generate
        for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
            mash_tap_line #(
                .DEPTH (TAPS)
            ) u_line (
                .clk      (clk),
                .rst      (rst),
                .shift_en (in_valid),
                .din      (dec[s]),
                .taps     (taps[s])
            );

            mash_cancel_path #(
                .KIND (path_kind_e'(s))
            ) u_path (
                .clk  (clk),
                .rst  (rst),
                .cur  (dec[s]),
                .taps (taps[s]),
                .psum (psum[s])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_s1 <= 1'b0;
        end else begin
            valid_s1 <= in_valid;
        end
    end

    mash_combiner #(
        .OUT_W    (OUT_W),
        .OUT_FRAC (OUT_FRAC)
    ) u_comb (
        .clk       (clk),
        .rst       (rst),
        .vin       (valid_s1),
        .p_a       (psum[0]),
        .p_b       (psum[1]),
        .p_c       (psum[2]),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    assign hist_flat = {taps[2], taps[1], taps[0]};
    assign dec_s1    = dec[0];
    assign taps_s1   = taps[0];

endmodule

// File: rtl/mash_nc_checker.sv
module mash_nc_checker
    import mash_nc_pkg::*;
#(
    parameter int OUT_W  = 11,
    parameter int HIST_W = NSTAGE * TAPS * 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [1:0]               code_s1,
    input logic                     out_valid,
    input logic signed [OUT_W-1:0]  out_word,
    input logic [HIST_W-1:0]        hist_flat,
    input tri_t                     dec_s1,
    input tri_t [TAPS-1:0]          taps_s1
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == '0));

    assert_code_map_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_s1 == 2'b11) |=> (taps_s1[0] == -2'sd1));

    assert_illegal_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_s1 == 2'b10) |=> (taps_s1[0] == 2'sd0));

    assert_shift_order_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (taps_s1[0] == $past(dec_s1) && taps_s1[1] == $past(taps_s1[0])
                      && taps_s1[2] == $past(taps_s1[1])));

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(hist_flat));

endmodule

bind mash_noise_cancel mash_nc_checker #(
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .code_s1   (code_s1),
    .out_valid (out_valid),
    .out_word  (out_word),
    .hist_flat (hist_flat),
    .dec_s1    (dec_s1),
    .taps_s1   (taps_s1)
);

// File: tb/tb_mash_noise_cancel.sv
module tb_mash_noise_cancel;

    localparam int CLK_PERIOD = 10;
    localparam int OUT_W      = 11;
    localparam int WMAX       = 1023;
    localparam int WMIN       = -1024;
    localparam int WATCHDOG   = 50000;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     in_valid = 1'b0;
    logic [1:0]               code_s1 = 2'b00;
    logic [1:0]               code_s2 = 2'b00;
    logic [1:0]               code_s3 = 2'b00;
    logic                     out_valid;
    logic signed [OUT_W-1:0]  out_word;

    mash_noise_cancel dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .code_s1   (code_s1),
        .code_s2   (code_s2),
        .code_s3   (code_s3),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    // behavioural model state
    int h1 [3];
    int h2 [3];
    int h3 [3];
    bit e_v [2];
    int e_w [2];
    int sat_pos = 0;
    int sat_neg = 0;
    string tag = "R1 reset";

    function automatic int dec(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b11) return -1;
        return 0;   // 2'b00 and illegal 2'b10
    endfunction

    task automatic report_end();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
            report_end();
        end
    end

    task automatic check(input string t, input bit ok, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, expv);
        end
    endtask

    // one clock: compare outputs, advance model, drive next inputs
    task automatic step(input bit r, input bit v,
                        input logic [1:0] c1, input logic [1:0] c2, input logic [1:0] c3);
        int x1, x2, x3, s, y;
        @(negedge clk);
        check({tag, " out_valid"}, out_valid == e_v[1], int'(out_valid), int'(e_v[1]));
        check({tag, " out_word"}, int'(out_word) == e_w[1], int'(out_word), e_w[1]);
        e_v[1] = e_v[0];
        e_w[1] = e_w[0];
        if (r) begin
            for (int k = 0; k < 3; k++) begin
                h1[k] = 0; h2[k] = 0; h3[k] = 0;
            end
            e_v[0] = 0; e_w[0] = 0; e_v[1] = 0; e_w[1] = 0;
        end else if (v) begin
            x1 = dec(c1); x2 = dec(c2); x3 = dec(c3);
            s = 32 * h1[2]
              + 32 * h2[0] - 64 * h2[1] + 33 * h2[2]
              + 32 * x3 - 96 * h3[0] + 97 * h3[1] - 33 * h3[2];
            y = s * 4;
            if (y > WMAX) y = WMAX;
            if (y < WMIN) y = WMIN;
            if (y == WMAX) sat_pos++;
            if (y == WMIN) sat_neg++;
            e_v[0] = 1;
            e_w[0] = y;
            h1[2] = h1[1]; h1[1] = h1[0]; h1[0] = x1;
            h2[2] = h2[1]; h2[1] = h2[0]; h2[0] = x2;
            h3[2] = h3[1]; h3[1] = h3[0]; h3[0] = x3;
        end else begin
            e_v[0] = 0;
            e_w[0] = 0;
        end
        rst      = r;
        in_valid = v;
        code_s1  = c1;
        code_s2  = c2;
        code_s3  = c3;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 2'b00, 2'b00, 2'b00);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            h1[k] = 0; h2[k] = 0; h3[k] = 0;
        end
        e_v[0] = 0; e_v[1] = 0; e_w[0] = 0; e_w[1] = 0;

        // R1: reset state, garbage codes ignored while in reset
        tag = "R1 reset";
        step(1, 0, 2'b01, 2'b11, 2'b01);
        step(1, 1, 2'b01, 2'b11, 2'b01);
        step(1, 0, 2'b00, 2'b00, 2'b00);
        idle(3);

        // R4: first-stage impulse appears 3 samples later with weight 1 (+128)
        tag = "R4 first-stage delay";
        step(0, 1, 2'b01, 2'b00, 2'b00);
        for (int i = 0; i < 5; i++) step(0, 1, 2'b00, 2'b00, 2'b00);
        idle(2);

        // R5: second-stage impulse, H1 taps 1, -2, 1.03125 one sample late
        tag = "R5 H1 path";
        step(0, 1, 2'b00, 2'b01, 2'b00);
        for (int i = 0; i < 5; i++) step(0, 1, 2'b00, 2'b00, 2'b00);
        idle(2);

        // R6 and R2: negative third-stage impulse via code 2'b11
        tag = "R6 R2 H2 path negative impulse";
        step(0, 1, 2'b00, 2'b00, 2'b11);
        for (int i = 0; i < 5; i++) step(0, 1, 2'b00, 2'b00, 2'b00);
        idle(2);

        // R3: illegal code 2'b10 on every stage acts as zero
        tag = "R3 illegal code";
        step(0, 1, 2'b10, 2'b10, 2'b10);
        step(0, 1, 2'b10, 2'b01, 2'b10);
        step(0, 1, 2'b01, 2'b10, 2'b11);
        for (int i = 0; i < 5; i++) step(0, 1, 2'b10, 2'b10, 2'b10);
        idle(2);

        // R10 and R9: samples interleaved with idle cycles
        tag = "R10 R9 gapped samples";
        for (int i = 0; i < 40; i++) begin
            step(0, 1, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)));
            idle(i % 4);
        end

        // R8 with R3: alternating codes drive the sum past both rails
        tag = "R8 R7 saturation with illegal codes";
        for (int i = 0; i < 16; i++) begin
            logic [1:0] a, b;
            a = (i % 2 == 0) ? 2'b01 : 2'b11;
            b = (i % 2 == 0) ? 2'b11 : 2'b01;
            step(0, 1, (i % 5 == 3) ? 2'b10 : a, b, a);
        end
        for (int i = 0; i < 8; i++) step(0, 1, 2'b10, 2'b00, 2'b00);
        idle(2);
        check("R8 positive rail reached", sat_pos > 0, sat_pos, 1);
        check("R8 negative rail reached", sat_neg > 0, sat_neg, 1);

        // R7: long random stream with back-to-back samples
        tag = "R7 random stream";
        for (int i = 0; i < 400; i++) begin
            step(0, ($urandom_range(0, 5) != 0), 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
        end

        // R1: reset in the middle of a stream clears history and pipeline
        tag = "R1 mid-stream reset";
        step(0, 1, 2'b01, 2'b01, 2'b01);
        step(1, 1, 2'b01, 2'b11, 2'b01);
        step(0, 1, 2'b00, 2'b00, 2'b00);
        for (int i = 0; i < 6; i++) step(0, 1, 2'b00, 2'b00, 2'b00);
        idle(3);

        if (!finished) begin
            finished = 1;
            report_end();
        end
    end

endmodule